// File: doc/BRIEF.md
# Overload Guard with Synchronized Recovery

This block watches an overload input from a motor power stage. When protection is enabled, it samples the input on a prescaled tick. The input is accepted as a real overload only after it has been seen active on a programmable number of consecutive samples. Once the overload is accepted, the block enters a protected state. In that state it drives a phase-disable mask for a chosen group of drive phases, and it can also assert a halt request for the PWM period counter.

The block leaves the protected state in one of three ways:
- a software request, which takes effect at once;
- the first PWM period sync pulse after the overload input has dropped;
- the first timer sync pulse after the overload input has dropped.

Each sync source has its own enable. After recovery the mask returns to all zeros, so the waveform settings that were in force before the overload apply again unchanged. The waveform generator downstream gates its phase outputs with the mask. It stops its counter while the halt output is high.

Top module: `ovl_guard`

## Requirements
- R1: While `en_i` is low, the block is held idle. On the clock edge that samples `en_i` low, `ovl_active_o` clears, and the prescaler and qualification counters reset to zero.
- R2: The prescaler produces a sample tick every `presc_i`+1 clock cycles. It counts from zero after the first edge at which `en_i` is high.
- R3: An overload is accepted when `ovl_i` is high on `qual_len_i` consecutive sample ticks, with a value of 0 treated as 1. A tick that sees `ovl_i` low resets the count to zero.
- R4: `ovl_active_o` reads 0 after reset. It rises on the clock edge of the accepting sample tick.
- R5: While the block is active, `phase_off_o` follows `mask_sel_i`:
  - 0: no phases.
  - 1: all phases.
  - 2: the phases flagged in `pwm_mode_i`.
  - 3: the upper half (indices 0 to NUM_PHASES/2-1) when `half_sel_i`=0, or the lower half when `half_sel_i`=1.

  While the block is idle, `phase_off_o` is zero.
- R6: `cnt_halt_o` is high exactly when the block is active and `halt_en_i` is high.
- R7: A high `sw_rec_i` while active clears `ovl_active_o` on the next edge. This happens even while `ovl_i` is still high and whatever the sync inputs are doing.
- R8: A sync-based exit needs `ovl_i` to have been sampled low during the protected state on an earlier edge. After that, `pwm_sync_i` with `pwm_rec_en_i`, or `tmr_sync_i` with `tmr_rec_en_i`, clears `ovl_active_o` on the next edge. A sync pulse whose enable is low has no effect.
- R9: After any recovery `phase_off_o` is zero. Qualification restarts from a count of zero, so a still-active input is accepted again after `qual_len_i` further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Protection enable |
| presc_i | input | PRESC_W | Sample tick divider minus one |
| qual_len_i | input | CNT_W | Consecutive active samples required |
| mask_sel_i | input | 2 | Phase group to disable |
| half_sel_i | input | 1 | 0 upper half, 1 lower half (for mask_sel_i=3) |
| pwm_mode_i | input | NUM_PHASES | Phases currently in PWM mode |
| halt_en_i | input | 1 | Request counter halt while protected |
| ovl_i | input | 1 | Overload input, active high |
| sw_rec_i | input | 1 | Software recovery request |
| pwm_rec_en_i | input | 1 | Allow recovery on PWM period sync |
| tmr_rec_en_i | input | 1 | Allow recovery on timer sync |
| pwm_sync_i | input | 1 | PWM period boundary pulse |
| tmr_sync_i | input | 1 | Timer event pulse |
| ovl_active_o | output | 1 | Protected state status |
| phase_off_o | output | NUM_PHASES | Phase disable mask |
| cnt_halt_o | output | 1 | PWM counter halt request |

## Verification
The bench uses the defaults NUM_PHASES=6, PRESC_W=4 and CNT_W=4. Six phases give three upper and three lower, so both half masks and a sparse PWM-mode mask can be told apart. The 4-bit fields allow prescaler divisions up to 16 and qualification lengths up to 15. The random phase keeps `presc_i` below 3 and `qual_len_i` below 4. This makes entry, recovery and requalification happen often within a few thousand cycles, including the case of a zero length treated as one.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    MASK_NONE  = 2'd0,
    MASK_ALL   = 2'd1,
    MASK_PWM   = 2'd2,
    MASK_HALF  = 2'd3
  } mask_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PROT = 1'b1
  } guard_st_e;
endpackage

// File: rtl/ovl_sampler.sv
module ovl_sampler #(
  parameter int PRESC_W = 4,
  parameter int CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               hold_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [CNT_W-1:0]   need_i,
  input  logic               ovl_i,
  output logic               hit_o
);
  localparam int CW1 = CNT_W + 1;

  logic [PRESC_W-1:0] pc_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               tick;
  logic [CW1-1:0]     cnt_inc;
  logic [CW1-1:0]     need_eff;

  assign tick     = (pc_q >= presc_i);
  assign cnt_inc  = {1'b0, cnt_q} + CW1'(1);
  assign need_eff = (need_i == '0) ? CW1'(1) : {1'b0, need_i};
  assign hit_o    = en_i && !hold_i && tick && ovl_i && (cnt_inc >= need_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (!en_i) begin
      pc_q <= '0;
    end else begin
      pc_q <= tick ? '0 : pc_q + PRESC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || hold_i || hit_o) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= ovl_i ? cnt_inc[CNT_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/ovl_phase_mask.sv
module ovl_phase_mask
  import ovl_pkg::*;
#(
  parameter int NUM_PHASES = 6
) (
  input  logic                  active_i,
  input  logic [1:0]            sel_i,
  input  logic                  half_sel_i,
  input  logic [NUM_PHASES-1:0] pwm_mode_i,
  output logic [NUM_PHASES-1:0] mask_o
);
  localparam int HALF = NUM_PHASES / 2;

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_ph
    localparam bit IS_UPPER = (g < HALF);
    logic sel_bit;
    always_comb begin
      unique case (mask_sel_e'(sel_i))
        MASK_NONE: sel_bit = 1'b0;
        MASK_ALL:  sel_bit = 1'b1;
        MASK_PWM:  sel_bit = pwm_mode_i[g];
        MASK_HALF: sel_bit = IS_UPPER ? !half_sel_i : half_sel_i;
        default:   sel_bit = 1'b0;
      endcase
    end
    assign mask_o[g] = active_i & sel_bit;
  end
endmodule

// File: rtl/ovl_guard.sv
module ovl_guard
  import ovl_pkg::*;
#(
  parameter int NUM_PHASES = 6,
  parameter int PRESC_W    = 4,
  parameter int CNT_W      = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [PRESC_W-1:0]    presc_i,
  input  logic [CNT_W-1:0]      qual_len_i,
  input  logic [1:0]            mask_sel_i,
  input  logic                  half_sel_i,
  input  logic [NUM_PHASES-1:0] pwm_mode_i,
  input  logic                  halt_en_i,
  input  logic                  ovl_i,
  input  logic                  sw_rec_i,
  input  logic                  pwm_rec_en_i,
  input  logic                  tmr_rec_en_i,
  input  logic                  pwm_sync_i,
  input  logic                  tmr_sync_i,
  output logic                  ovl_active_o,
  output logic [NUM_PHASES-1:0] phase_off_o,
  output logic                  cnt_halt_o
);
  guard_st_e st_q, st_d;
  logic      arm_q, arm_d;
  logic      hit;
  logic      sync_ev;
  logic      prot;

  assign prot    = (st_q == ST_PROT);
  assign sync_ev = (pwm_rec_en_i && pwm_sync_i) || (tmr_rec_en_i && tmr_sync_i);

  ovl_sampler #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_smp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .hold_i  (prot),
    .presc_i (presc_i),
    .need_i  (qual_len_i),
    .ovl_i   (ovl_i),
    .hit_o   (hit)
  );

  always_comb begin
    st_d  = st_q;
    arm_d = arm_q;
    if (!en_i) begin
      st_d  = ST_IDLE;
      arm_d = 1'b0;
    end else if (!prot) begin
      arm_d = 1'b0;
      if (hit) st_d = ST_PROT;
    end else begin
      // software wins; sync needs a prior low sample of ovl_i
      if (sw_rec_i || (arm_q && sync_ev)) begin
        st_d  = ST_IDLE;
        arm_d = 1'b0;
      end else if (!ovl_i) begin
        arm_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      arm_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      arm_q <= arm_d;
    end
  end

  ovl_phase_mask #(.NUM_PHASES(NUM_PHASES)) u_mask (
    .active_i   (prot),
    .sel_i      (mask_sel_i),
    .half_sel_i (half_sel_i),
    .pwm_mode_i (pwm_mode_i),
    .mask_o     (phase_off_o)
  );

  assign ovl_active_o = prot;
  assign cnt_halt_o   = prot & halt_en_i;
endmodule

// File: rtl/ovl_guard_chk.sv
module ovl_guard_chk #(
  parameter int NUM_PHASES = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  en_i,
  input logic [1:0]            mask_sel_i,
  input logic                  ovl_i,
  input logic                  sw_rec_i,
  input logic                  ovl_active_o,
  input logic [NUM_PHASES-1:0] phase_off_o,
  input logic                  cnt_halt_o
);
  p_disable_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ovl_active_o);

  p_entry_needs_input_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovl_active_o) |-> $past(ovl_i));

  p_idle_mask_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovl_active_o |-> (phase_off_o == '0));

  p_all_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_active_o && mask_sel_i == 2'd1) |-> (&phase_off_o));

  p_halt_only_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_halt_o |-> ovl_active_o);

  p_sw_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_active_o && sw_rec_i && en_i) |=> !ovl_active_o);
endmodule

bind ovl_guard ovl_guard_chk #(.NUM_PHASES(NUM_PHASES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .mask_sel_i   (mask_sel_i),
  .ovl_i        (ovl_i),
  .sw_rec_i     (sw_rec_i),
  .ovl_active_o (ovl_active_o),
  .phase_off_o  (phase_off_o),
  .cnt_halt_o   (cnt_halt_o)
);

// File: tb/ovl_guard_tb_top.sv
module ovl_guard_tb_top;
  localparam int NP = 6;
  localparam int PW = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [PW-1:0] presc = '0;
  logic [CW-1:0] qual = '0;
  logic [1:0]    msel = '0;
  logic          half = 1'b0;
  logic [NP-1:0] pmode = '0;
  logic          halt_en = 1'b0;
  logic          ovl = 1'b0;
  logic          sw = 1'b0;
  logic          pwm_en = 1'b0;
  logic          tmr_en = 1'b0;
  logic          pwm_sync = 1'b0;
  logic          tmr_sync = 1'b0;
  logic          act;
  logic [NP-1:0] mask;
  logic          halt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ovl_guard #(.NUM_PHASES(NP), .PRESC_W(PW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .presc_i(presc), .qual_len_i(qual),
    .mask_sel_i(msel), .half_sel_i(half), .pwm_mode_i(pmode), .halt_en_i(halt_en),
    .ovl_i(ovl), .sw_rec_i(sw), .pwm_rec_en_i(pwm_en), .tmr_rec_en_i(tmr_en),
    .pwm_sync_i(pwm_sync), .tmr_sync_i(tmr_sync),
    .ovl_active_o(act), .phase_off_o(mask), .cnt_halt_o(halt)
  );

  // reference model built from the requirements
  int m_pc, m_cnt;
  bit m_act, m_arm;

  function automatic logic [NP-1:0] exp_mask(bit a, logic [1:0] s, logic h, logic [NP-1:0] pm);
    logic [NP-1:0] r;
    r = '0;
    if (a) begin
      case (s)
        2'd0: r = '0;
        2'd1: r = '1;
        2'd2: r = pm;
        default: for (int i = 0; i < NP; i++) r[i] = (i < NP/2) ? !h : h;
      endcase
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_cnt = 0; m_act = 0; m_arm = 0;
    end else if (!en) begin
      m_pc = 0; m_cnt = 0; m_act = 0; m_arm = 0;
    end else begin
      bit tk, arm_old;
      int need;
      tk = (m_pc >= int'(presc));
      m_pc = tk ? 0 : m_pc + 1;
      need = (qual == 0) ? 1 : int'(qual);
      arm_old = m_arm;
      if (m_act) begin
        m_cnt = 0;
        if (sw || (arm_old && ((pwm_en && pwm_sync) || (tmr_en && tmr_sync)))) begin
          m_act = 0; m_arm = 0;
        end else if (!ovl) m_arm = 1;
      end else if (tk) begin
        if (ovl) begin
          if (m_cnt + 1 >= need) begin m_act = 1; m_cnt = 0; m_arm = 0; end
          else m_cnt = m_cnt + 1;
        end else m_cnt = 0;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    chk("R4 reset active", act, 0);
    chk("R5 reset mask", mask, 0);
    chk("R6 reset halt", halt, 0);
    rst_n = 1'b1;
    en = 1; presc = 0; qual = 3; msel = 1; halt_en = 1;
    step(1);
    // qualification
    ovl = 1;
    step(2); chk("R3 not yet qualified", act, 0);
    step(1); chk("R4 active after third sample", act, 1);
    chk("R5 all phases", mask, 6'h3f);
    chk("R6 halt while active", halt, 1);
    // software recovery while input high
    sw = 1; step(1); sw = 0;
    chk("R7 sw exit with input high", act, 0);
    chk("R9 mask cleared", mask, 0);
    step(2); chk("R9 requalify count restarts", act, 0);
    step(1); chk("R9 requalified", act, 1);
    // PWM sync recovery
    pwm_en = 1; pwm_sync = 1; step(1); pwm_sync = 0;
    chk("R8 sync ignored while input high", act, 1);
    ovl = 0; step(1); chk("R8 still active after drop", act, 1);
    pwm_sync = 1; step(1); pwm_sync = 0; pwm_en = 0;
    chk("R8 pwm sync exit", act, 0);
    chk("R9 mask zero after sync exit", mask, 0);
    // timer sync gated by its enable
    ovl = 1; step(3); chk("R4 reenter", act, 1);
    ovl = 0; step(1);
    tmr_sync = 1; step(1); chk("R8 timer sync ignored when disabled", act, 1);
    tmr_en = 1; step(1); tmr_sync = 0; tmr_en = 0;
    chk("R8 timer sync exit", act, 0);
    // mask variants
    ovl = 1; step(3); chk("R4 reenter for masks", act, 1);
    msel = 2; pmode = 6'b101001; #1 chk("R5 pwm phases", mask, 6'b101001);
    msel = 3; half = 0; #1 chk("R5 upper half", mask, 6'b000111);
    half = 1; #1 chk("R5 lower half", mask, 6'b111000);
    msel = 0; #1 chk("R5 no phases", mask, 0);
    halt_en = 0; #1 chk("R6 halt disabled", halt, 0);
    // disable
    en = 0; step(1); chk("R1 disable clears active", act, 0);
    ovl = 0; step(1);
    // prescaler timing
    presc = 3; qual = 2; msel = 1; ovl = 1; en = 1;
    step(7); chk("R2 before second tick", act, 0);
    step(1); chk("R2 entry on second tick", act, 1);
    en = 0; ovl = 0; step(2);
    en = 1; step(1);
    // random phase against the model
    for (int c = 0; c < 4000; c++) begin
      chk("R4 model active", act, m_act);
      chk("R5 model mask", mask, exp_mask(m_act, msel, half, pmode));
      chk("R6 model halt", halt, m_act && halt_en);
      en       = ($urandom % 100) < 98;
      if (($urandom % 50) == 0) begin
        presc = PW'($urandom % 3); qual = CW'($urandom % 4);
        msel = 2'($urandom); half = 1'($urandom); pmode = NP'($urandom);
        halt_en = 1'($urandom); pwm_en = 1'($urandom); tmr_en = 1'($urandom);
      end
      if (($urandom % 10) == 0) ovl = !ovl;
      sw       = ($urandom % 40) == 0;
      pwm_sync = ($urandom % 8) == 0;
      tmr_sync = ($urandom % 12) == 0;
      step(1);
    end
    finish_run();
  end

  initial void'($urandom(32'h5eed_0042));
endmodule